// File: doc/BRIEF.md
# I2C Register Target with Retained Pointer and Wiring-Swap Addressing

This block is the serial host interface of a sensor. It lets a bus controller read and write an 8-bit-addressed register file through a two-wire open-drain bus with 7-bit target addressing. An internal register pointer selects the register for each data byte. It advances after every data byte and keeps its value across STOP conditions. A read that names only the target address therefore carries on from where the previous access left off.

The two pad pins need not be wired the same way on every board. After reset the block watches the first bus access, and the pin that falls first while both are high is taken as the data line. The block ignores that access, so the controller sees a NACK. When the access ends with a STOP, the pin roles are fixed until the next reset. A normally wired device answers to the primary address 0x39. A device with its pins swapped answers to a second address set by a parameter. Two identical sensors can therefore share one bus.

Each pad input passes through a synchronizer and a glitch filter before any edge is decoded. Because of this the block works at any bus rate well below the system clock, including standard-mode and fast-mode rates. The register file sits outside the block and is reached through an address, write-data, write-strobe and read-data port.

Top module: `i2c_ptr_target`

## Requirements
- R1: With normal wiring, the block acknowledges the 7-bit address 0x39. The first byte after START carries the address in bits 7..1 and the direction in bit 0, where 1 means read.
- R2: With the pins swapped (data on pin B, clock on pin A), the block acknowledges only the alternate address parameter and NACKs 0x39. The pin roles stay fixed until reset.
- R3: After reset, the block drives neither pin during the first access, so that access is NACKed whatever its address. The pin roles are settled by the STOP that ends that access.
- R4: In a write, the first data byte after the address loads the pointer. Each later byte is written to the register at the pointer with a write strobe that lasts one clock.
- R5: The pointer increases by one after every data byte that is read or written, and it wraps from 0xFF to 0x00.
- R6: The pointer keeps its value across STOP. A read that sends only the address byte returns data starting at the retained pointer.
- R7: Read data goes out MSB first. Reading continues while the controller ACKs each byte. A controller NACK ends the read and the block releases the data line.
- R8: An address byte that does not match is NACKed, causes no register write and leaves the pointer unchanged.
- R9: A repeated START begins a new address phase, so a pointer write followed by a repeated-START read returns data from the new pointer.
- R10: A pulse shorter than FILT_CYCLES clocks on a pad input has no effect on the bus decoding.
- R11: After reset, no pin is driven, no write strobe is active and the register address output is 0x00.
- R12: Transfers are decoded correctly at fast-mode (about 400 kHz) and standard-mode (about 100 kHz) bus clock rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 1 | Pad A level (data line with normal wiring) |
| pin_b_i | input | 1 | Pad B level (clock line with normal wiring) |
| pin_a_oe_o | output | 1 | Pull pad A low when 1 |
| pin_b_oe_o | output | 1 | Pull pad B low when 1 |
| reg_addr_o | output | 8 | Register file address (the pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-clock register write strobe |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
The hardest state to reach from the ports is the swapped-wiring role with its alternate address. It exists only after a reset, a physically swapped connection and a full dummy access that ends in STOP. The bench gets there by swapping the two host lines between the host model and the pins. It then resets the block, runs the NACKed dummy access, and shows that 0x39 is refused while the alternate address reads back its own writes. A second hard case is a sub-filter pulse in the middle of a clock-high phase. The host model injects a two-clock low pulse on the clock line inside a data bit and checks that the byte is stored intact. Pointer wrap and pointer retention are reached with directed bursts at 0xFE and 0xFF and with address-less reads. These are mixed with seeded random bursts at varied bus rates.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    // protocol engine phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_e;

    // pin role discovery phases
    typedef enum logic [1:0] {
        SW_WAIT_START,
        SW_WAIT_STOP,
        SW_LOCKED
    } role_state_e;

endpackage

// File: rtl/i2ct_pin_filter.sv
module i2ct_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    localparam int CW  = $clog2(FILT_CYCLES + 1);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], pin_i};
        if (q.sync[MSB] == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYCLES - 1)) begin
            d.out = q.sync[MSB];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
            q.out  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pin_o = q.out;

    // R10
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out != $past(q.out)) |-> ($past(q.sync[MSB]) == q.out));

endmodule

// File: rtl/i2ct_role_select.sv
module i2ct_role_select
    import i2ct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pa_i,
    input  logic pb_i,
    input  logic sda_oe_i,
    output logic sda_o,
    output logic scl_o,
    output logic swapped_o,
    output logic pin_a_oe_o,
    output logic pin_b_oe_o
);
    typedef struct packed {
        role_state_e st;
        logic        swapped;
        logic        pa;
        logic        pb;
    } role_t;

    role_t q, d;
    logic  dat_now, dat_prev, clk_now, clk_prev, locked;

    always_comb begin
        dat_now  = q.swapped ? pb_i : pa_i;
        dat_prev = q.swapped ? q.pb : q.pa;
        clk_now  = q.swapped ? pa_i : pb_i;
        clk_prev = q.swapped ? q.pa : q.pb;
    end

    always_comb begin
        d    = q;
        d.pa = pa_i;
        d.pb = pb_i;
        case (q.st)
            SW_WAIT_START: begin
                if (q.pa && q.pb) begin
                    if (!pa_i && pb_i) begin
                        d.st      = SW_WAIT_STOP;
                        d.swapped = 1'b0;
                    end else if (pa_i && !pb_i) begin
                        d.st      = SW_WAIT_STOP;
                        d.swapped = 1'b1;
                    end
                end
            end
            SW_WAIT_STOP: begin
                if (clk_prev && clk_now && !dat_prev && dat_now)
                    d.st = SW_LOCKED;
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= SW_WAIT_START;
            q.swapped <= 1'b0;
            q.pa      <= 1'b1;
            q.pb      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign locked     = (q.st == SW_LOCKED);
    assign sda_o      = locked ? (q.swapped ? pb_i : pa_i) : 1'b1;
    assign scl_o      = locked ? (q.swapped ? pa_i : pb_i) : 1'b1;
    assign swapped_o  = q.swapped;
    assign pin_a_oe_o = locked && !q.swapped && sda_oe_i;
    assign pin_b_oe_o = locked &&  q.swapped && sda_oe_i;

    // R2
    role_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_LOCKED) |=> (q.st == SW_LOCKED) && $stable(q.swapped));

    // R3
    dummy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SW_LOCKED) |-> !(pin_a_oe_o || pin_b_oe_o));

    // R2
    single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_a_oe_o && pin_b_oe_o));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic [DATA_W-2:0] my_addr_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] FULL = BIT_W'(DATA_W);

    typedef struct packed {
        eng_state_e        st;
        logic              sda_p;
        logic              scl_p;
        logic [DATA_W-1:0] sh;
        logic [BIT_W-1:0]  bits;
        logic              rw;
        logic              first;
        logic              nack;
        logic              oe;
        logic [DATA_W-1:0] ptr;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } eng_t;

    eng_t q, d;
    logic scl_rise, scl_fall, start_c, stop_c;

    always_comb begin
        scl_rise = scl_i && !q.scl_p;
        scl_fall = !scl_i && q.scl_p;
        start_c  = q.scl_p && scl_i && q.sda_p && !sda_i;
        stop_c   = q.scl_p && scl_i && !q.sda_p && sda_i;
    end

    always_comb begin
        d       = q;
        d.sda_p = sda_i;
        d.scl_p = scl_i;
        d.we    = 1'b0;
        if (q.we) d.ptr = q.ptr + 1'b1;

        if (start_c) begin
            d.st    = ST_ADDR;
            d.bits  = '0;
            d.sh    = '0;
            d.oe    = 1'b0;
            d.first = 1'b1;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[DATA_W-2:0], sda_i};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == FULL) begin
                        if (q.sh[DATA_W-1:1] == my_addr_i) begin
                            d.rw = q.sh[0];
                            d.oe = 1'b1;
                            d.st = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.sh = reg_rdata_i;
                            d.oe = !reg_rdata_i[DATA_W-1];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[DATA_W-2:0], sda_i};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == FULL) begin
                        d.oe = 1'b1;
                        d.st = ST_WR_ACK;
                        if (q.first) begin
                            d.ptr   = q.sh;
                            d.first = 1'b0;
                        end else begin
                            d.we    = 1'b1;
                            d.wdata = q.sh;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.st   = ST_WR;
                        d.bits = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bits == FULL) begin
                            d.oe  = 1'b0;
                            d.st  = ST_RD_ACK;
                            d.ptr = q.ptr + 1'b1;
                        end else begin
                            d.sh = {q.sh[DATA_W-2:0], 1'b0};
                            d.oe = !q.sh[DATA_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.nack = sda_i;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_RD;
                            d.bits = '0;
                            d.sh   = reg_rdata_i;
                            d.oe   = !reg_rdata_i[DATA_W-1];
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.sda_p <= 1'b1;
            q.scl_p <= 1'b1;
            q.sh    <= '0;
            q.bits  <= '0;
            q.rw    <= 1'b0;
            q.first <= 1'b1;
            q.nack  <= 1'b0;
            q.oe    <= 1'b0;
            q.ptr   <= '0;
            q.we    <= 1'b0;
            q.wdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign reg_addr_o  = q.ptr;
    assign reg_wdata_o = q.wdata;
    assign reg_we_o    = q.we;

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> (q.ptr == $past(q.ptr) + 1'b1));

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !q.oe);

    // R8
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !start_c) |=> !q.oe && !q.we);

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-2:0] PRIMARY_ADDR = 7'h39,
    parameter logic [DATA_W-2:0] ALT_ADDR     = 7'h29,
    parameter int                SYNC_STAGES  = 2,
    parameter int                FILT_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a_i,
    input  logic              pin_b_i,
    output logic              pin_a_oe_o,
    output logic              pin_b_oe_o,
    output logic [DATA_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins_raw, pins_flt;
    logic             sda, scl, swapped, sda_oe;
    logic [DATA_W-2:0] my_addr;

    assign pins_raw = {pin_b_i, pin_a_i};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        i2ct_pin_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_i(pins_raw[i]),
            .pin_o(pins_flt[i])
        );
    end

    i2ct_role_select u_role (
        .clk       (clk),
        .rst_n     (rst_n),
        .pa_i      (pins_flt[0]),
        .pb_i      (pins_flt[1]),
        .sda_oe_i  (sda_oe),
        .sda_o     (sda),
        .scl_o     (scl),
        .swapped_o (swapped),
        .pin_a_oe_o(pin_a_oe_o),
        .pin_b_oe_o(pin_b_oe_o)
    );

    assign my_addr = swapped ? ALT_ADDR : PRIMARY_ADDR;

    i2ct_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda),
        .scl_i      (scl),
        .my_addr_i  (my_addr),
        .reg_rdata_i(reg_rdata_i),
        .sda_oe_o   (sda_oe),
        .reg_addr_o (reg_addr_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_we_o   (reg_we_o)
    );

endmodule

// File: tb/i2c_ptr_target_test.sv
module i2c_ptr_target_test;
    localparam logic [6:0] PRI = 7'h39;
    localparam logic [6:0] ALT = 7'h52;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic swap_wire = 1'b0;
    logic host_sda_low = 1'b0, host_scl_low = 1'b0;
    logic uut_a_oe, uut_b_oe;
    wire  pa = !((swap_wire ? host_scl_low : host_sda_low) || uut_a_oe);
    wire  pb = !((swap_wire ? host_sda_low : host_scl_low) || uut_b_oe);
    wire  sda_bus = swap_wire ? pb : pa;

    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic [7:0] dev_mem [256];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dev_mem[i] <= 8'h00;
        end else if (reg_we) begin
            dev_mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = dev_mem[reg_addr];

    i2c_ptr_target #(.PRIMARY_ADDR(PRI), .ALT_ADDR(ALT)) uut (
        .clk(clk), .rst_n(rst_n), .pin_a_i(pa), .pin_b_i(pb),
        .pin_a_oe_o(uut_a_oe), .pin_b_oe_o(uut_b_oe),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    int q = 25;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;
    logic [7:0] tx [16];
    logic [7:0] rx [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ptr_after(input logic [7:0] p, input int n);
        return 8'(int'(p) + n);
    endfunction

    task automatic wait_q();
        repeat (q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda_low = 1'b1; wait_q();
        host_scl_low = 1'b1; wait_q();
    endtask

    task automatic bus_rstart();
        host_sda_low = 1'b0; wait_q();
        host_scl_low = 1'b0; wait_q();
        host_sda_low = 1'b1; wait_q();
        host_scl_low = 1'b1; wait_q();
    endtask

    task automatic bus_stop();
        host_sda_low = 1'b1; wait_q();
        host_scl_low = 1'b0; wait_q();
        host_sda_low = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda_low = !b[i]; wait_q();
            host_scl_low = 1'b0; wait_q();
            if (glitch && i == 3) begin
                host_scl_low = 1'b1;
                repeat (2) @(negedge clk);
                host_scl_low = 1'b0;
            end
            wait_q();
            host_scl_low = 1'b1; wait_q();
        end
        host_sda_low = 1'b0; wait_q();
        host_scl_low = 1'b0; wait_q();
        ack = !sda_bus;
        wait_q();
        host_scl_low = 1'b1; wait_q();
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] b);
        host_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            host_scl_low = 1'b0; wait_q();
            b[i] = sda_bus;
            wait_q();
            host_scl_low = 1'b1;
        end
        wait_q();
        host_sda_low = host_ack; wait_q();
        host_scl_low = 1'b0; wait_q(); wait_q();
        host_scl_low = 1'b1; wait_q();
        host_sda_low = 1'b0;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                          input bit glitch, output bit addr_ack, output bit all_ack);
        bit k;
        bus_start();
        send_byte({a, 1'b0}, 1'b0, addr_ack);
        all_ack = addr_ack;
        send_byte(p, 1'b0, k); all_ack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], glitch, k); all_ack &= k;
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [6:0] a, input bit with_ptr, input logic [7:0] p,
                          input int n, output bit addr_ack);
        bit k;
        bus_start();
        if (with_ptr) begin
            send_byte({a, 1'b0}, 1'b0, k);
            send_byte(p, 1'b0, k);
            bus_rstart();
        end
        send_byte({a, 1'b1}, 1'b0, addr_ack);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rx[i]);
        bus_stop();
    endtask

    task automatic model_write(input logic [7:0] p, input int n);
        for (int i = 0; i < n; i++) exp_mem[ptr_after(p, i)] = tx[i];
        exp_ptr = ptr_after(p, n);
    endtask

    task automatic do_reset(input bit swapped);
        rst_n = 1'b0;
        host_sda_low = 1'b0; host_scl_low = 1'b0;
        swap_wire = swapped;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        exp_ptr = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic dummy_access(input logic [6:0] a, input string tag);
        bit k;
        bus_start();
        send_byte({a, 1'b0}, 1'b0, k);
        check({tag, " dummy access NACK"}, {31'd0, k}, 32'd0);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit aa, all;
        logic [7:0] p, start;
        int n;
        void'($urandom(32'd2024));

        do_reset(1'b0);
        // R11 reset state
        check("R11 pin A released", {31'd0, uut_a_oe}, 32'd0);
        check("R11 pin B released", {31'd0, uut_b_oe}, 32'd0);
        check("R11 no write strobe", {31'd0, reg_we}, 32'd0);
        check("R11 pointer zero", {24'd0, reg_addr}, 32'd0);

        // R3 first access NACKed even at own address
        dummy_access(PRI, "R3");

        // R1 R4 write burst at 0x10
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'hE1; tx[3] = 8'h96;
        wr_txn(PRI, 8'h10, 4, 1'b0, aa, all);
        check("R1 primary address ACK", {31'd0, aa}, 32'd1);
        check("R4 all write bytes ACK", {31'd0, all}, 32'd1);
        model_write(8'h10, 4);

        // R9 R7 pointer load then repeated start read
        rd_txn(PRI, 1'b1, 8'h10, 2, aa);
        check("R9 read after repeated start ACK", {31'd0, aa}, 32'd1);
        check("R7 R9 byte0", {24'd0, rx[0]}, {24'd0, exp_mem[8'h10]});
        check("R7 R4 byte1", {24'd0, rx[1]}, {24'd0, exp_mem[8'h11]});
        exp_ptr = 8'h12;

        // R6 address-less read continues at retained pointer
        rd_txn(PRI, 1'b0, 8'h00, 1, aa);
        check("R6 retained pointer read", {24'd0, rx[0]}, {24'd0, exp_mem[exp_ptr]});
        exp_ptr = ptr_after(exp_ptr, 1);

        // R12 standard-mode rate address-less read
        q = 312;
        rd_txn(PRI, 1'b0, 8'h00, 1, aa);
        check("R12 R6 standard-mode read", {24'd0, rx[0]}, {24'd0, exp_mem[exp_ptr]});
        exp_ptr = ptr_after(exp_ptr, 1);
        q = 25;

        // R5 wrap from 0xFF to 0x00
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
        wr_txn(PRI, 8'hFE, 4, 1'b0, aa, all);
        model_write(8'hFE, 4);
        check("R5 wrap write stored at 0x01", {24'd0, dev_mem[8'h01]}, 32'h44);
        rd_txn(PRI, 1'b1, 8'hFF, 2, aa);
        check("R5 read 0xFF", {24'd0, rx[0]}, 32'h22);
        check("R5 read wraps to 0x00", {24'd0, rx[1]}, 32'h33);
        exp_ptr = ptr_after(8'hFF, 2);

        // R8 foreign address ignored
        tx[0] = 8'h99;
        wr_txn(7'h3A, 8'h40, 1, 1'b0, aa, all);
        check("R8 foreign address NACK", {31'd0, aa}, 32'd0);
        check("R8 no register write", {24'd0, dev_mem[8'h40]}, 32'h00);
        rd_txn(PRI, 1'b0, 8'h00, 1, aa);
        check("R8 pointer unchanged", {24'd0, rx[0]}, {24'd0, exp_mem[exp_ptr]});
        exp_ptr = ptr_after(exp_ptr, 1);

        // R10 short clock glitch inside a data bit
        tx[0] = 8'h5A;
        wr_txn(PRI, 8'h20, 1, 1'b1, aa, all);
        model_write(8'h20, 1);
        check("R10 glitch burst ACK", {31'd0, all}, 32'd1);
        rd_txn(PRI, 1'b1, 8'h20, 1, aa);
        check("R10 glitched byte intact", {24'd0, rx[0]}, 32'h5A);

        // R12 fast-mode rate
        q = 78;
        tx[0] = 8'hC3;
        wr_txn(PRI, 8'h30, 1, 1'b0, aa, all);
        model_write(8'h30, 1);
        rd_txn(PRI, 1'b1, 8'h30, 1, aa);
        check("R12 fast-mode readback", {24'd0, rx[0]}, 32'hC3);

        // random bursts, R4 R5 R6 R7
        for (int it = 0; it < 9; it++) begin
            q = $urandom_range(36, 20);
            p = 8'($urandom_range(255, 0));
            n = $urandom_range(3, 1);
            for (int i = 0; i < n; i++) tx[i] = 8'($urandom_range(255, 0));
            wr_txn(PRI, p, n, 1'b0, aa, all);
            check("R4 random write ACK", {31'd0, all}, 32'd1);
            model_write(p, n);
            start = p;
            rd_txn(PRI, 1'b1, start, n, aa);
            for (int i = 0; i < n; i++)
                check("R7 random readback", {24'd0, rx[i]}, {24'd0, exp_mem[ptr_after(start, i)]});
            exp_ptr = ptr_after(start, n);
            if (it % 3 == 0) begin
                rd_txn(PRI, 1'b0, 8'h00, 1, aa);
                check("R6 random continuation", {24'd0, rx[0]}, {24'd0, exp_mem[exp_ptr]});
                exp_ptr = ptr_after(exp_ptr, 1);
            end
        end

        // R2 swapped wiring selects alternate address
        q = 25;
        do_reset(1'b1);
        dummy_access(ALT, "R3 swapped");
        tx[0] = 8'h6B;
        wr_txn(PRI, 8'h05, 1, 1'b0, aa, all);
        check("R2 primary NACK when swapped", {31'd0, aa}, 32'd0);
        wr_txn(ALT, 8'h05, 1, 1'b0, aa, all);
        check("R2 alternate address ACK", {31'd0, all}, 32'd1);
        model_write(8'h05, 1);
        rd_txn(ALT, 1'b1, 8'h05, 1, aa);
        check("R2 alternate readback", {24'd0, rx[0]}, 32'h6B);
        check("R2 pin A never driven as data", {31'd0, uut_a_oe}, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule